// File: doc/BRIEF.md
# Serial-Bus Node Control and Status Register Bank

This block holds the control and status registers that a node on a serial bus shows to the other nodes: its node identifier, the split-transaction timeout pair, a small state word, and the four shared isochronous-resource registers that bus nodes claim by atomic compare-and-swap. A request carries a kind (read, write or lock), a byte offset inside the register space, a byte length and, for locks, an extended code, a compare argument and a swap operand. Exactly one cycle later the bank answers with a response code and one quadlet of data.

The resource registers accept atomic compare-and-swap locks and nothing else. Every other register has its own write mask and its own values after power-up and after bus reset. Offsets that the bank does not decode return an address error. A request that is well formed but of the wrong kind for its register returns a type error. A bus-reset strobe reloads the resource registers and the node identifier. An is-root input decides whether the cycle-master bit of the state word survives that reset.

Top module: `csr_bank`

## Requirements
- R1: After rst_ni is asserted and after every cycle with bus_reset_i high, the registers read back as follows: bus-manager ID (offset 0x21C) holds 0x3F, bandwidth (0x220) holds 4915, and channel-high (0x224) and channel-low (0x228) hold 0xFFFFFFFF.
- R2: A lock with extended code 2 (compare-swap) on offsets 0x21C..0x228 completes and returns the register's value from before the lock. The register takes the swap operand only when its value equals the compare argument. Otherwise it keeps its value.
- R3: A lock on a resource register with any extended code other than 2 returns a type error and leaves the register as it was. A lock on 0x000, 0x004, 0x008, 0x00C, 0x018 or 0x01C returns a type error. A lock on any other aligned offset returns an address error.
- R4: A write to any of the four resource registers returns a type error and leaves the register as it was.
- R5: A request of any kind whose offset is not a multiple of four returns a type error. A read or write whose length is not a multiple of four returns a type error and changes nothing.
- R6: Split-timeout-high (0x018) keeps only bits 2..0 of a write, and split-timeout-low (0x01C) keeps only bits 31..19. After power-up they read 0 and 0x19000000. A bus reset does not change either one.
- R7: The node-ID register (0x008) powers up as 0. A write takes bits 31..22 from the data, keeps bits 21..16, and clears bits 15..0. A bus reset loads {node_id_i, 16'h0}.
- R8: The state word reads back at both 0x000 and 0x004. A write to 0x004 sets the bits that are 1 in the data, and a write to 0x000 clears them. It powers up as 0. A bus reset keeps only bits 9..8, and also clears bit 8 when is_root_i is low.
- R9: At 0x00C a read returns a type error and a write completes with no effect. A read or write at any aligned offset not listed in R1, R6, R7 or R8 returns an address error.
- R10: The response comes exactly one cycle after the request edge, and rsp_valid_o is high only in that cycle. Request kinds are encoded 0 read, 1 write, 2 lock; kind 3 returns a type error. Response codes are 0 complete, 6 type error, 7 address error. Writes and errors return data 0.
- R11: Locks in back-to-back cycles are serialised. The second lock compares against the value that the first one left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 0 read, 1 write, 2 lock |
| req_off_i | input | OFF_W | Byte offset in register space |
| req_len_i | input | LEN_W | Byte length of read or write |
| req_ext_i | input | EXT_W | Extended lock code |
| req_data_i | input | 32 | Write data or lock swap operand |
| req_arg_i | input | 32 | Lock compare argument |
| bus_reset_i | input | 1 | One-cycle bus-reset strobe |
| is_root_i | input | 1 | Node is root of the bus |
| node_id_i | input | 16 | Node's own ID, loaded on bus reset |
| rsp_valid_o | output | 1 | Response present |
| rsp_code_o | output | 3 | Response code |
| rsp_data_o | output | 32 | Read data or old lock value |

## Verification
The assertions on lock results take a request to be independent of bus_reset_i in the same cycle. The swap and keep properties exclude that cycle outright, because the strobe takes priority over the swap there. The bench never raises bus_reset_i while a request is present, so every lock it issues is checked against R2. It drives one request per cycle for one cycle and changes inputs only on falling edges, so each request edge is unambiguous for the one-cycle response property.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int unsigned NUM_RES = 4;

  localparam logic [1:0] K_READ  = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_LOCK  = 2'd2;

  localparam logic [2:0] RC_DONE = 3'd0;
  localparam logic [2:0] RC_TYPE = 3'd6;
  localparam logic [2:0] RC_ADDR = 3'd7;

  localparam int unsigned OFF_STCLR  = 'h000;
  localparam int unsigned OFF_STSET  = 'h004;
  localparam int unsigned OFF_NODE   = 'h008;
  localparam int unsigned OFF_RSTART = 'h00C;
  localparam int unsigned OFF_SPLHI  = 'h018;
  localparam int unsigned OFF_SPLLO  = 'h01C;
  localparam int unsigned OFF_RES    = 'h21C;

  typedef enum logic [2:0] {
    SEL_STCLR, SEL_STSET, SEL_NODE, SEL_RSTART,
    SEL_SPLHI, SEL_SPLLO, SEL_RES, SEL_NONE
  } sel_e;
endpackage

// File: rtl/csr_bank_decode.sv
module csr_bank_decode
  import csr_bank_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  localparam int unsigned WORD_W = OFF_W - 2,
  localparam int unsigned IDX_W = $clog2(NUM_RES)
) (
  input  logic [WORD_W-1:0] word_i,
  output sel_e              sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (word_i == WORD_W'(OFF_STCLR >> 2))       sel_o = SEL_STCLR;
    else if (word_i == WORD_W'(OFF_STSET >> 2))  sel_o = SEL_STSET;
    else if (word_i == WORD_W'(OFF_NODE >> 2))   sel_o = SEL_NODE;
    else if (word_i == WORD_W'(OFF_RSTART >> 2)) sel_o = SEL_RSTART;
    else if (word_i == WORD_W'(OFF_SPLHI >> 2))  sel_o = SEL_SPLHI;
    else if (word_i == WORD_W'(OFF_SPLLO >> 2))  sel_o = SEL_SPLLO;
    for (int i = 0; i < NUM_RES; i++) begin
      if (word_i == WORD_W'((OFF_RES >> 2) + i)) begin
        sel_o = SEL_RES;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/csr_bank_resource.sv
module csr_bank_resource
  import csr_bank_pkg::*;
#(
  parameter logic [31:0] MGR_INIT = 32'h3F,
  parameter logic [31:0] BW_INIT  = 32'd4915,
  localparam int unsigned IDX_W = $clog2(NUM_RES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_reset_i,
  input  logic                     lock_en_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [31:0]              cmp_i,
  input  logic [31:0]              swap_i,
  output logic [NUM_RES-1:0][31:0] val_o
);
  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    localparam logic [31:0] INIT = (g == 0) ? MGR_INIT : (g == 1) ? BW_INIT : '1;
    logic hit;
    assign hit = lock_en_i && (idx_i == IDX_W'(g)) && (val_o[g] == cmp_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          val_o[g] <= INIT;
      else if (bus_reset_i) val_o[g] <= INIT;  // strobe wins over a same-cycle swap
      else if (hit)         val_o[g] <= swap_i;
    end
  end
endmodule

// File: rtl/csr_bank_cfg.sv
module csr_bank_cfg
  import csr_bank_pkg::*;
#(
  parameter logic [31:0] SPLIT_LO_INIT = 32'd800 << 19
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_reset_i,
  input  logic        is_root_i,
  input  logic [15:0] node_id_i,
  input  logic        wr_en_i,
  input  sel_e        sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] state_o,
  output logic [31:0] node_o,
  output logic [31:0] spl_hi_o,
  output logic [31:0] spl_lo_o
);
  localparam logic [31:0] KEEP_ST  = 32'h0000_0300;
  localparam logic [31:0] CMSTR    = 32'h0000_0100;
  localparam logic [31:0] BUS_MASK = 32'hFFC0_0000;
  localparam logic [31:0] NOD_MASK = 32'h003F_0000;
  localparam logic [31:0] HI_MASK  = 32'h0000_0007;
  localparam logic [31:0] LO_MASK  = 32'hFFF8_0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= '0;
      node_o   <= '0;
      spl_hi_o <= '0;
      spl_lo_o <= SPLIT_LO_INIT & LO_MASK;
    end else if (bus_reset_i) begin
      state_o <= state_o & KEEP_ST & (is_root_i ? '1 : ~CMSTR);
      node_o  <= {node_id_i, 16'h0};
    end else if (wr_en_i) begin
      case (sel_i)
        SEL_STCLR: state_o  <= state_o & ~wdata_i;
        SEL_STSET: state_o  <= state_o | wdata_i;
        SEL_NODE:  node_o   <= (node_o & NOD_MASK) | (wdata_i & BUS_MASK);
        SEL_SPLHI: spl_hi_o <= wdata_i & HI_MASK;
        SEL_SPLLO: spl_lo_o <= wdata_i & LO_MASK;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned LEN_W      = 10,
  parameter int unsigned EXT_W      = 4,
  parameter logic [EXT_W-1:0] CSWAP = EXT_W'(2),
  parameter logic [31:0] MGR_INIT   = 32'h3F,
  parameter logic [31:0] BW_INIT    = 32'd4915,
  parameter logic [31:0] SPLIT_LO_INIT = 32'd800 << 19,
  localparam int unsigned IDX_W = $clog2(NUM_RES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [EXT_W-1:0] req_ext_i,
  input  logic [31:0]      req_data_i,
  input  logic [31:0]      req_arg_i,
  input  logic             bus_reset_i,
  input  logic             is_root_i,
  input  logic [15:0]      node_id_i,
  output logic             rsp_valid_o,
  output logic [2:0]       rsp_code_o,
  output logic [31:0]      rsp_data_o
);
  sel_e sel;
  logic [IDX_W-1:0] idx;
  logic [NUM_RES-1:0][31:0] res_q;
  logic [31:0] state_q, node_q, spl_hi_q, spl_lo_q;
  logic off_ok, len_ok, wr_en, lock_en;
  logic [2:0]  code;
  logic [31:0] rdata;

  assign off_ok = (req_off_i & OFF_W'(3)) == '0;
  assign len_ok = (req_len_i & LEN_W'(3)) == '0;

  csr_bank_decode #(.OFF_W(OFF_W)) u_dec (
    .word_i(req_off_i[OFF_W-1:2]), .sel_o(sel), .idx_o(idx)
  );

  csr_bank_resource #(.MGR_INIT(MGR_INIT), .BW_INIT(BW_INIT)) u_res (
    .clk_i, .rst_ni, .bus_reset_i, .lock_en_i(lock_en), .idx_i(idx),
    .cmp_i(req_arg_i), .swap_i(req_data_i), .val_o(res_q)
  );

  csr_bank_cfg #(.SPLIT_LO_INIT(SPLIT_LO_INIT)) u_cfg (
    .clk_i, .rst_ni, .bus_reset_i, .is_root_i, .node_id_i,
    .wr_en_i(wr_en), .sel_i(sel), .wdata_i(req_data_i),
    .state_o(state_q), .node_o(node_q), .spl_hi_o(spl_hi_q), .spl_lo_o(spl_lo_q)
  );

  always_comb begin
    code    = RC_ADDR;
    rdata   = '0;
    wr_en   = 1'b0;
    lock_en = 1'b0;
    if (!off_ok) begin
      code = RC_TYPE;
    end else begin
      case (req_kind_i)
        K_READ: begin
          if (!len_ok) code = RC_TYPE;
          else case (sel)
            SEL_STCLR, SEL_STSET: begin code = RC_DONE; rdata = state_q;    end
            SEL_NODE:             begin code = RC_DONE; rdata = node_q;     end
            SEL_SPLHI:            begin code = RC_DONE; rdata = spl_hi_q;   end
            SEL_SPLLO:            begin code = RC_DONE; rdata = spl_lo_q;   end
            SEL_RES:              begin code = RC_DONE; rdata = res_q[idx]; end
            SEL_RSTART:           code = RC_TYPE;
            default:              code = RC_ADDR;
          endcase
        end
        K_WRITE: begin
          if (!len_ok) code = RC_TYPE;
          else case (sel)
            SEL_STCLR, SEL_STSET, SEL_NODE, SEL_SPLHI, SEL_SPLLO: begin
              code  = RC_DONE;
              wr_en = req_valid_i;
            end
            SEL_RSTART: code = RC_DONE;
            SEL_RES:    code = RC_TYPE;
            default:    code = RC_ADDR;
          endcase
        end
        K_LOCK: begin
          if (sel == SEL_RES) begin
            if (req_ext_i == CSWAP) begin
              code    = RC_DONE;
              rdata   = res_q[idx];
              lock_en = req_valid_i;
            end else begin
              code = RC_TYPE;
            end
          end else if (sel == SEL_NONE) begin
            code = RC_ADDR;
          end else begin
            code = RC_TYPE;
          end
        end
        default: code = RC_TYPE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RC_DONE;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_code_o  <= req_valid_i ? code  : RC_DONE;
      rsp_data_o  <= req_valid_i ? rdata : '0;
    end
  end
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
  import csr_bank_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned LEN_W = 10,
  parameter int unsigned EXT_W = 4,
  parameter logic [EXT_W-1:0] CSWAP = EXT_W'(2),
  parameter logic [31:0] MGR_INIT = 32'h3F,
  parameter logic [31:0] BW_INIT  = 32'd4915
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic [1:0]               req_kind_i,
  input logic [OFF_W-1:0]         req_off_i,
  input logic [LEN_W-1:0]         req_len_i,
  input logic [EXT_W-1:0]         req_ext_i,
  input logic [31:0]              req_data_i,
  input logic [31:0]              req_arg_i,
  input logic                     bus_reset_i,
  input logic                     rsp_valid_o,
  input logic [2:0]               rsp_code_o,
  input logic [31:0]              rsp_data_o,
  input logic [NUM_RES-1:0][31:0] res_q
);
  logic in_res, bw_lock;
  assign in_res  = req_off_i >= OFF_W'(OFF_RES) && req_off_i < OFF_W'(OFF_RES + 4 * NUM_RES)
                   && req_off_i[1:0] == 2'b00;
  assign bw_lock = req_valid_i && req_kind_i == K_LOCK && req_ext_i == CSWAP
                   && req_off_i == OFF_W'(OFF_RES + 4);

  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);  // R10
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);  // R10
  AST_MISALIGN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_off_i[1:0] != 2'b00 |=> rsp_code_o == RC_TYPE);  // R5
  AST_MISALIGN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_kind_i != K_LOCK && req_len_i[1:0] != 2'b00 |=> rsp_code_o == RC_TYPE);  // R5
  AST_RES_WRITE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_kind_i == K_WRITE && in_res |=> rsp_code_o == RC_TYPE);  // R4
  AST_LOCK_EXT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_kind_i == K_LOCK && in_res && req_ext_i != CSWAP |=> rsp_code_o == RC_TYPE);  // R3
  AST_LOCK_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_lock |=> rsp_code_o == RC_DONE && rsp_data_o == $past(res_q[1]));  // R2
  AST_LOCK_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_lock && !bus_reset_i && res_q[1] == req_arg_i |=> res_q[1] == $past(req_data_i));  // R2
  AST_LOCK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_lock && !bus_reset_i && res_q[1] != req_arg_i |=> $stable(res_q[1]));  // R2
  AST_BUS_RESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> res_q[0] == MGR_INIT && res_q[1] == BW_INIT && &res_q[2] && &res_q[3]);  // R1
  AST_SPLIT_HI_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_kind_i == K_READ && req_off_i == OFF_W'(OFF_SPLHI) && req_len_i[1:0] == 2'b00
    |=> rsp_data_o[31:3] == '0);  // R6
endmodule

bind csr_bank csr_bank_chk #(
  .OFF_W(OFF_W), .LEN_W(LEN_W), .EXT_W(EXT_W), .CSWAP(CSWAP),
  .MGR_INIT(MGR_INIT), .BW_INIT(BW_INIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
  .req_off_i(req_off_i), .req_len_i(req_len_i), .req_ext_i(req_ext_i),
  .req_data_i(req_data_i), .req_arg_i(req_arg_i), .bus_reset_i(bus_reset_i),
  .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o), .rsp_data_o(rsp_data_o),
  .res_q(res_q)
);

// File: tb/csr_bank_test.sv
module csr_bank_test;
  localparam int OFF_W = 12;
  localparam int LEN_W = 10;
  localparam int EXT_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [1:0] req_kind_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic [EXT_W-1:0] req_ext_i = '0;
  logic [31:0] req_data_i = '0, req_arg_i = '0;
  logic bus_reset_i = 1'b0, is_root_i = 1'b0;
  logic [15:0] node_id_i = '0;
  logic rsp_valid_o;
  logic [2:0] rsp_code_o;
  logic [31:0] rsp_data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  csr_bank uut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_kind_i, .req_off_i, .req_len_i,
    .req_ext_i, .req_data_i, .req_arg_i, .bus_reset_i, .is_root_i, .node_id_i,
    .rsp_valid_o, .rsp_code_o, .rsp_data_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input int off, input int len,
                       input logic [31:0] d, input logic [31:0] a, input int ext);
    req_valid_i = 1'b1;
    req_kind_i  = k;
    req_off_i   = OFF_W'(off);
    req_len_i   = LEN_W'(len);
    req_data_i  = d;
    req_arg_i   = a;
    req_ext_i   = EXT_W'(ext);
  endtask

  // one request, response sampled on the following falling edge
  task automatic req(input logic [1:0] k, input int off, input int len,
                     input logic [31:0] d, input logic [31:0] a, input int ext);
    @(negedge clk);
    drive(k, off, len, d, a, ext);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic rd_chk(input string r, input int off, input logic [31:0] exp);
    req(2'd0, off, 4, '0, '0, 0);
    chk({r, " code"}, 32'(rsp_code_o), 0);
    chk({r, " data"}, rsp_data_o, exp);
  endtask

  task automatic bus_reset(input logic root, input logic [15:0] id);
    @(negedge clk);
    is_root_i = root;
    node_id_i = id;
    bus_reset_i = 1'b1;
    @(negedge clk);
    bus_reset_i = 1'b0;
  endtask

  function automatic bit is_res(int off);
    return off >= 'h21C && off <= 'h228;
  endfunction
  function automatic bit is_other(int off);
    return off == 0 || off == 4 || off == 8 || off == 'hC || off == 'h18 || off == 'h1C;
  endfunction
  function automatic logic [31:0] init_val(int off);
    case (off)
      'h01C: return 32'd800 * 32'd524288;
      'h21C: return 32'h3F;
      'h220: return 32'd4915;
      'h224, 'h228: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", 32'(rsp_valid_o), 0);

    // R1 R6 R7 R8 R9: read sweep of every quadlet offset after power-up
    for (int off = 0; off < (1 << OFF_W); off += 4) begin
      logic [2:0] ec;
      req(2'd0, off, 4, '0, '0, 0);
      ec = (is_res(off) || (is_other(off) && off != 'hC)) ? 3'd0 : (off == 'hC) ? 3'd6 : 3'd7;
      chk("R9 read sweep code", 32'(rsp_code_o), 32'(ec));
      chk("R1 read sweep data", rsp_data_o, (ec == 0) ? init_val(off) : 32'h0);
      chk("R10 read rsp valid", 32'(rsp_valid_o), 1);
    end

    // R5: misaligned offsets on every kind, misaligned lengths on read/write
    for (int off = 0; off < 64; off++) begin
      if (off % 4 != 0) begin
        for (int k = 0; k < 3; k++) begin
          req(2'(k), off, 4, '1, '0, 2);
          chk("R5 offset misaligned", 32'(rsp_code_o), 6);
        end
      end
    end
    for (int len = 1; len < 12; len++) begin
      if (len % 4 != 0) begin
        req(2'd0, 'h8, len, '0, '0, 0);
        chk("R5 read length misaligned", 32'(rsp_code_o), 6);
        req(2'd1, 'h18, len, 32'h5, '0, 0);
        chk("R5 write length misaligned", 32'(rsp_code_o), 6);
      end
    end
    rd_chk("R5 split hi untouched", 'h18, 0);

    // R3 R2: lock sweep with compare-swap code and a non-matching argument
    for (int off = 0; off < (1 << OFF_W); off += 4) begin
      req(2'd2, off, 4, 32'h1111_1111, 32'h5A5A_5A5A, 2);
      chk("R3 lock sweep code", 32'(rsp_code_o), is_res(off) ? 0 : is_other(off) ? 6 : 7);
      chk("R2 lock sweep old value", rsp_data_o, is_res(off) ? init_val(off) : 32'h0);
    end
    for (int off = 'h21C; off <= 'h228; off += 4)
      rd_chk("R2 mismatch leaves value", off, init_val(off));

    // R3: every other extended code with a matching argument
    for (int off = 'h21C; off <= 'h228; off += 4) begin
      for (int ext = 0; ext < 16; ext++) begin
        if (ext != 2) begin
          req(2'd2, off, 4, 32'h0, init_val(off), ext);
          chk("R3 ext code rejected", 32'(rsp_code_o), 6);
        end
      end
      rd_chk("R3 ext reject no change", off, init_val(off));
    end

    // R4: plain writes to resource registers
    for (int off = 'h21C; off <= 'h228; off += 4) begin
      req(2'd1, off, 4, 32'h0, '0, 0);
      chk("R4 write rejected", 32'(rsp_code_o), 6);
      chk("R10 error data zero", rsp_data_o, 0);
      rd_chk("R4 write no change", off, init_val(off));
    end

    // R2: matching swap, then a mismatch against the new value
    req(2'd2, 'h220, 4, 32'd4000, 32'd4915, 2);
    chk("R2 swap returns old", rsp_data_o, 32'd4915);
    rd_chk("R2 swap stored", 'h220, 32'd4000);
    req(2'd2, 'h220, 4, 32'd1, 32'd4915, 2);
    chk("R2 mismatch returns current", rsp_data_o, 32'd4000);
    rd_chk("R2 mismatch kept", 'h220, 32'd4000);

    // R11: back-to-back locks on the bus-manager register
    @(negedge clk);
    drive(2'd2, 'h21C, 4, 32'd5, 32'h3F, 2);
    @(negedge clk);
    chk("R11 first lock old", rsp_data_o, 32'h3F);
    drive(2'd2, 'h21C, 4, 32'd9, 32'd5, 2);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R11 second lock sees first", rsp_data_o, 32'd5);
    chk("R11 second lock code", 32'(rsp_code_o), 0);
    rd_chk("R11 final value", 'h21C, 32'd9);

    // R6: write masks on the split-timeout pair
    req(2'd1, 'h18, 4, 32'hFFFF_FFFF, '0, 0);
    chk("R6 write complete", 32'(rsp_code_o), 0);
    chk("R10 write data zero", rsp_data_o, 0);
    rd_chk("R6 split hi mask", 'h18, 32'h7);
    req(2'd1, 'h1C, 4, 32'h0007_FFFF, '0, 0);
    rd_chk("R6 split lo low bits dropped", 'h1C, 32'h0);
    req(2'd1, 'h1C, 4, 32'hFFFF_FFFF, '0, 0);
    rd_chk("R6 split lo mask", 'h1C, 32'hFFF8_0000);

    // R8: set and clear views of the state word
    req(2'd1, 'h4, 4, 32'hFFFF_FFFF, '0, 0);
    rd_chk("R8 state set", 'h0, 32'hFFFF_FFFF);
    req(2'd1, 'h0, 4, 32'h0000_F00F, '0, 0);
    rd_chk("R8 state clear", 'h4, 32'hFFFF_0FF0);

    // R1 R6 R7 R8: bus reset as root
    bus_reset(1'b1, 16'hFFC5);
    rd_chk("R8 root keeps bits 9..8", 'h0, 32'h0000_0300);
    rd_chk("R7 node loaded", 'h8, 32'hFFC5_0000);
    rd_chk("R6 split hi survives", 'h18, 32'h7);
    rd_chk("R6 split lo survives", 'h1C, 32'hFFF8_0000);
    for (int off = 'h21C; off <= 'h228; off += 4)
      rd_chk("R1 bus reset reload", off, init_val(off));

    // R7: bus field replaced, node field kept
    req(2'd1, 'h8, 4, 32'h1230_ABCD, '0, 0);
    rd_chk("R7 node write", 'h8, 32'h1205_0000);

    // R9: reset-start write completes with no effect
    req(2'd1, 'hC, 4, 32'hFFFF_FFFF, '0, 0);
    chk("R9 reset-start write", 32'(rsp_code_o), 0);
    rd_chk("R9 state unchanged", 'h0, 32'h0000_0300);
    req(2'd1, 'h200, 4, 32'h1, '0, 0);
    chk("R9 unimplemented write", 32'(rsp_code_o), 7);

    // R8: bus reset when not root clears cycle-master bit
    req(2'd1, 'h4, 4, 32'hFFFF_FFFF, '0, 0);
    bus_reset(1'b0, 16'h0041);
    rd_chk("R8 non-root clears bit 8", 'h0, 32'h0000_0200);
    rd_chk("R7 node reload", 'h8, 32'h0041_0000);

    // R10: unused kind
    req(2'd3, 'h8, 4, '0, '0, 0);
    chk("R10 kind 3 type error", 32'(rsp_code_o), 6);
    @(negedge clk);
    chk("R10 idle after request", 32'(rsp_valid_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule